// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block manages 32 general-purpose pins, grouped into four banks of eight. Each bank has its own 64-byte register window. The window holds the pin directions, the output latch, the sampled input levels, the interrupt status, the interrupt mask and the per-pin trigger type. Software uses a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. Only bits 7:0 of a word carry bank data. The upper read bits are always zero.

Pin inputs pass through a two-flop synchronizer before anything else sees them. A pin can raise its interrupt in one of two modes. In edge mode a rising edge sets a sticky status bit, which software clears by writing 1 to it. In level mode the status bit follows the synchronized pin level. Masking uses two registers: one write sets mask bits and another write clears them. All the unmasked status bits of all banks are ORed into one interrupt line.

Top module: `gpio_banked`

## Requirements
- R1: After reset every pin is an input, so `pin_oe` is 0. All output latches are 0 and every mask register reads 0xFF. All status bits and trigger-type bits are 0, and `irq` is low.
- R2: Pin N belongs to bank N/8 at bit N mod 8. Bank k uses byte addresses k*0x40 through k*0x40+0x3F, and address bits 7:6 select the bank.
- R3: Writing offset 0x0C clears the mask bits written as 1, which unmasks those pins. Reading offset 0x0C returns 0.
- R4: Reading offset 0x08 returns the bank's mask. Writing it sets the mask bits written as 1 and leaves the other mask bits unchanged.
- R5: Reading offset 0x04 returns the raw status. In edge mode, writing 1 to a bit there clears it. A rising edge in the same cycle takes priority over the clear.
- R6: Offset 0x00 returns status AND NOT mask. Writes to it change nothing.
- R7: Offset 0x10 holds the direction, with 1 for input and 0 for output. `pin_oe` is the inverse of the direction bit. `pin_out` carries the latch value on output pins and 0 on input pins.
- R8: Offset 0x14 is the output latch and reads back the value last written to it.
- R9: Offset 0x18 returns the pin levels after two synchronizing flops. A pin change becomes readable two clock edges after it is applied, not one. Writes to this offset are ignored.
- R10: In edge mode (trigger bit 0 at offset 0x20), a rising edge of the synchronized input sets the status bit. The bit stays set after the pin falls and is cleared only by a write to offset 0x04.
- R11: In level mode (trigger bit 1 at offset 0x20), the status bit follows the synchronized pin level. Offset 0x20 reads back the trigger bits.
- R12: `irq` is high exactly when any bank has a bit that is set in status and clear in mask.
- R13: Every offset that is not listed above reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data; bits 7:0 used |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 32 | Pin levels, asynchronous |
| pin_out | output | 32 | Output values |
| pin_oe | output | 32 | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench checks that bank decoding puts pin 10 at bit 2 of the second window. A design that ignored address bits 7:6 would show the pin in every bank. It checks that an edge-mode status bit stays set after the pin falls, which a design that treated edges as levels would lose. It also checks that a level-mode bit drops with the pin. The bench samples the input register one edge after a pin change and again two edges after it, which exposes a missing or an extra synchronizer stage. It confirms that the unmask register reads zero, and that writes to the masked-status register and to an unmapped offset leave every register unchanged.

// File: rtl/gpio_banked.sv
module gpio_banked #(
  parameter int BANKS = 4,
  parameter int BW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [BANKS*BW-1:0] pin_in,
  output logic [BANKS*BW-1:0] pin_out,
  output logic [BANKS*BW-1:0] pin_oe,
  output logic                irq
);
  localparam int NP = BANKS * BW;
  localparam logic [5:0] O_MSTAT = 6'h00, O_STAT = 6'h04, O_MSET = 6'h08,
                         O_MCLR = 6'h0C, O_DIR = 6'h10, O_OUT = 6'h14,
                         O_IN = 6'h18, O_TRIG = 6'h20;

  logic [NP-1:0] dir_q, out_q, mask_q, stat_q, trig_q;
  logic [NP-1:0] s1, s2, s3, rise;
  logic [NP-1:0] w_stat, w_mset, w_mclr, w_dir, w_out, w_trig, en_dir, en_out, en_trig;
  logic [5:0] off;
  logic [1:0] bsel;

  assign off  = bus_addr[5:0];
  assign bsel = bus_addr[7:6];
  assign rise = s2 & ~s3;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_we && (bsel == b[1:0]);
    assign w_stat [b*BW +: BW] = (hit && off == O_STAT) ? bus_wdata[BW-1:0] : '0;
    assign w_mset [b*BW +: BW] = (hit && off == O_MSET) ? bus_wdata[BW-1:0] : '0;
    assign w_mclr [b*BW +: BW] = (hit && off == O_MCLR) ? bus_wdata[BW-1:0] : '0;
    assign en_dir [b*BW +: BW] = {BW{hit && off == O_DIR}};
    assign en_out [b*BW +: BW] = {BW{hit && off == O_OUT}};
    assign en_trig[b*BW +: BW] = {BW{hit && off == O_TRIG}};
    assign w_dir  [b*BW +: BW] = bus_wdata[BW-1:0];
    assign w_out  [b*BW +: BW] = bus_wdata[BW-1:0];
    assign w_trig [b*BW +: BW] = bus_wdata[BW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      dir_q <= '1; out_q <= '0; mask_q <= '1; stat_q <= '0; trig_q <= '0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      s3 <= s2;
      dir_q  <= (dir_q & ~en_dir) | (w_dir & en_dir);
      out_q  <= (out_q & ~en_out) | (w_out & en_out);
      trig_q <= (trig_q & ~en_trig) | (w_trig & en_trig);
      mask_q <= (mask_q | w_mset) & ~w_mclr;
      stat_q <= (trig_q & s2) | (~trig_q & ((stat_q & ~w_stat) | rise));
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (off)
      O_MSTAT: bus_rdata[BW-1:0] = stat_q[bsel*BW +: BW] & ~mask_q[bsel*BW +: BW];
      O_STAT:  bus_rdata[BW-1:0] = stat_q[bsel*BW +: BW];
      O_MSET:  bus_rdata[BW-1:0] = mask_q[bsel*BW +: BW];
      O_DIR:   bus_rdata[BW-1:0] = dir_q[bsel*BW +: BW];
      O_OUT:   bus_rdata[BW-1:0] = out_q[bsel*BW +: BW];
      O_IN:    bus_rdata[BW-1:0] = s2[bsel*BW +: BW];
      O_TRIG:  bus_rdata[BW-1:0] = trig_q[bsel*BW +: BW];
      default: bus_rdata = '0;
    endcase
  end

  assign pin_oe  = ~dir_q;
  assign pin_out = out_q & ~dir_q;
  assign irq     = |(stat_q & ~mask_q);

  a_r3_unmask_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (off == O_MCLR) |-> (bus_rdata == 32'h0));

  a_r3_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && off == O_MCLR) |=> ((mask_q & $past(w_mclr)) == '0));

  a_r4_mask_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && off == O_MSET) |=> ((mask_q & $past(w_mset)) == $past(w_mset)));

  a_r5_clear_wins_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && off == O_STAT) |=> ((stat_q & $past(w_stat & ~trig_q & ~rise)) == '0));

  a_r10_sticky_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~trig_q & ~w_stat)) == $past(stat_q & ~trig_q & ~w_stat)));

  a_r11_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(trig_q & s2)) == $past(trig_q & s2)));
endmodule

// File: tb/sim_gpio_banked.sv
module sim_gpio_banked;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  gpio_banked u0 (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
                  .pin_in, .pin_out, .pin_oe, .irq);

  always #(CLK_NS/2) clk = ~clk;

  // fields: req[80:73] we[72] addr[71:64] wdata[63:32] expected[31:0]
  localparam logic [80:0] VEC [10] = '{
    {8'd7,  1'b1, 8'h10, 32'h0F, 32'h0F},   // R7 direction bank0
    {8'd8,  1'b1, 8'h54, 32'hA5, 32'hA5},   // R8 latch bank1
    {8'd3,  1'b1, 8'hCC, 32'h0F, 32'hF0},   // R3 unmask then read 0xC8
    {8'd3,  1'b0, 8'hCC, 32'h00, 32'h00},   // R3 reads zero
    {8'd4,  1'b1, 8'hC8, 32'h01, 32'hF1},   // R4 set one bit
    {8'd11, 1'b1, 8'hA0, 32'h3C, 32'h3C},   // R11 trigger readback
    {8'd13, 1'b1, 8'h1C, 32'hFF, 32'h00},   // R13 unmapped
    {8'd6,  1'b1, 8'h00, 32'hFF, 32'h00},   // R6 read-only
    {8'd9,  1'b1, 8'h18, 32'hFF, 32'h00},   // R9 input ignores writes
    {8'd2,  1'b0, 8'h50, 32'h00, 32'hFF}    // R2 bank1 direction untouched
  };
  localparam logic [7:0] RD_ADDR [10] = '{8'h10, 8'h54, 8'hC8, 8'hCC, 8'hC8,
                                          8'hA0, 8'h1C, 8'h00, 8'h18, 8'h50};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1 bus_we = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); bus_addr = a; #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clocks(3); #1 rst_n = 1;
    // R1 reset state
    rd("R1", 8'h10, 32'hFF);
    rd("R1", 8'hC8, 32'hFF);
    rd("R1", 8'h94, 32'h00);
    rd("R1", 8'h64, 32'h00);
    rd("R1", 8'hE0, 32'h00);
    chk("R1", {pin_oe, 31'd0, irq}, 64'h0);

    foreach (VEC[i]) begin
      if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
      rd($sformatf("R%0d", VEC[i][80:73]), RD_ADDR[i], VEC[i][31:0]);
    end

    // R7 outputs: bank0 pins 0-3 input, 4-7 output
    wr(8'h14, 32'hFF);
    @(negedge clk);
    chk("R7", pin_oe, 32'h0000_00F0);
    chk("R7", pin_out, 32'h0000_00F0);

    // R2 pin 10 is bank1 bit2
    pin_in = 32'h0000_0400; clocks(4);
    rd("R2", 8'h58, 32'h04);
    rd("R2", 8'h18, 32'h00);
    // R10 sticky edge
    rd("R10", 8'h44, 32'h04);
    pin_in = 0; clocks(4);
    rd("R10", 8'h44, 32'h04);
    rd("R6", 8'h40, 32'h00);
    chk("R12", {31'd0, irq}, 32'h0);
    wr(8'h4C, 32'h04);
    rd("R6", 8'h40, 32'h04);
    @(negedge clk); chk("R12", {31'd0, irq}, 32'h1);
    wr(8'h44, 32'h04);
    rd("R5", 8'h44, 32'h00);
    @(negedge clk); chk("R12", {31'd0, irq}, 32'h0);

    // R11 level mode on pin 24
    wr(8'hE0, 32'h01);
    pin_in = 32'h0100_0000; clocks(4);
    rd("R11", 8'hC4, 32'h01);
    pin_in = 0; clocks(4);
    rd("R11", 8'hC4, 32'h00);

    // R9 two-stage latency on pin 31
    @(negedge clk); pin_in = 32'h8000_0000; bus_addr = 8'hD8;
    @(negedge clk); #1 chk("R9", bus_rdata, 32'h00);
    @(negedge clk); #1 chk("R9", bus_rdata, 32'h80);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule